// File: doc/BRIEF.md
# Flash Region Lock and Security Controller

This block sits between a command source and a flash back end. The flash is split into equal regions of consecutive pages, and the block keeps one protection bit for each region plus a single security bit. Commands arrive on a one-cycle request port. They can protect a region, unprotect it, turn security on, or ask for a page program or page erase. A program or erase aimed at a protected region never reaches the back end. Instead it completes with an error and an interrupt pulse. An accepted request becomes a one-cycle strobe towards the back end, carrying the request address.

An external erase line gives a recovery path. The line must stay high for a programmable number of consecutive clocks before it counts. Once it counts, and the system is not parked in a deep low-power wait, the block clears every protection bit and asks the back end for a whole-array erase. Security is dropped only when the back end reports that this erase has finished. While security is on, the debug-access and fast-programming enables are held low.

Top module: `flash_guard`

## Requirements
- R1: Command codes on `cmdOp` are 1 = protect region, 2 = unprotect region, 3 = enable security, 4 = program page, 5 = erase page. The region index is `cmdAddr` divided by `REGION_BYTES`, taken from the upper address bits.
- R2: A program or erase request to a protected region sets `cmdDone`, `cmdErr` and `irq` for exactly one cycle, in the cycle after the request. It produces no back-end strobe.
- R3: A program or erase request to an unprotected region sets `cmdDone` with `cmdErr` low in the cycle after the request. In that same cycle it pulses `flashPgmStb` or `flashErsStb` respectively, with `flashAddr` equal to the request address.
- R4: A protect request affects only the addressed region, and an unprotect request reverses it. Each one completes with `cmdDone` high and `cmdErr` low.
- R5: An enable-security request sets `secureOn` and forces `dbgEnable` and `fastPgmEnable` low from the next cycle. No command code clears `secureOn`.
- R6: The erase line qualifies only after `QUAL_CYCLES` consecutive high samples. Any low sample restarts the count, and shorter pulses have no effect.
- R7: In the cycle after qualification, all protection bits are cleared and `flashEraseAllStb` pulses for exactly one cycle.
- R8: `secureOn` stays set while the whole-array erase is pending. It is cleared in the cycle after `flashEraseAllDone` is seen, and only then.
- R9: While `lowPowerDeep` is high, a qualified erase line does not start the sequence. The sequence starts in the cycle after `lowPowerDeep` falls, provided the line is still qualified.
- R10: A request made while the erase sequence is running, or one carrying code 0, 6 or 7, completes with `cmdErr` high and `irq` low and has no effect.
- R11: One continuous high period of the erase line starts at most one sequence.
- R12: After reset all regions are unprotected, `secureOn` is low, both access enables are high and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle request strobe |
| cmdOp | input | 3 | Request code |
| cmdAddr | input | ADDR_W | Request byte address |
| cmdDone | output | 1 | Request completion pulse |
| cmdErr | output | 1 | Request rejected, valid with cmdDone |
| irq | output | 1 | Protection-violation interrupt pulse |
| flashPgmStb | output | 1 | Page program strobe to the back end |
| flashErsStb | output | 1 | Page erase strobe to the back end |
| flashAddr | output | ADDR_W | Address for the page strobes |
| flashEraseAllStb | output | 1 | Whole-array erase request pulse |
| flashEraseAllDone | input | 1 | Back end reports whole-array erase finished |
| eraseIn | input | 1 | External erase line |
| lowPowerDeep | input | 1 | System in wait state with flash powered down |
| secureOn | output | 1 | Security bit |
| dbgEnable | output | 1 | Debug access permitted |
| fastPgmEnable | output | 1 | Fast programming access permitted |

## Verification
The bench sweeps several protection patterns over every region, including none, all and two mixed ones. It then probes both the lowest and the highest address of each region with both page operations. This separates wrong index slicing from a wrong per-region bit. The erase line is driven three ways: with pulses one cycle short of qualification, with two such pulses split by a single low sample, and with a qualified hold. This tells a correct counter restart apart from one that merely accumulates. The qualified hold is run first under low power and then with an extended high period, which exposes a missing gate and a retrigger. Requests issued during the pending erase, and every command code issued under security, show that no path other than erase completion can release security.

// File: rtl/fg_pkg.sv
package fg_pkg;

  // request codes decoded by the control
  typedef enum logic [2:0] {
    OP_SETLOCK = 3'd1,
    OP_CLRLOCK = 3'd2,
    OP_SETSEC  = 3'd3,
    OP_PROGRAM = 3'd4,
    OP_ERASE   = 3'd5
  } fg_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setSec;
    logic wipeLocks;
    logic clrSec;
    logic startSeq;
  } fg_strobe_t;

endpackage

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int NUM_REGIONS  = 128,
  parameter int REGION_BYTES = 8192,
  parameter int QUAL_CYCLES  = 64,
  parameter int ADDR_W       = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  fg_strobe_t        strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              eraseIn,
  output logic              lockHit,
  output logic              qualified,
  output logic              seqFired,
  output logic              secureOn
);

  localparam int OFS_W = $clog2(REGION_BYTES);
  localparam int IDX_W = $clog2(NUM_REGIONS);
  localparam int QC_W  = $clog2(QUAL_CYCLES + 1);

  logic [IDX_W-1:0] region;
  logic             lockBits [NUM_REGIONS];
  logic [QC_W-1:0]  qualCnt;

  assign region  = cmdAddr[OFS_W +: IDX_W];
  assign lockHit = lockBits[region];

  // one protection flop per region; the erase sequence overrides commands
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          lockBits[g] <= 1'b0;
      else if (strb.wipeLocks)            lockBits[g] <= 1'b0;
      else if (region == IDX_W'(g)) begin
        if (strb.clrLock)                 lockBits[g] <= 1'b0;
        else if (strb.setLock)            lockBits[g] <= 1'b1;
      end
    end
  end

  // consecutive-high counter, saturating at the qualification limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 qualCnt <= '0;
    else if (!eraseIn)                         qualCnt <= '0;
    else if (qualCnt != QC_W'(QUAL_CYCLES))    qualCnt <= qualCnt + 1'b1;
  end
  assign qualified = (qualCnt == QC_W'(QUAL_CYCLES));

  // one sequence per high period of the erase line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              seqFired <= 1'b0;
    else if (strb.startSeq) seqFired <= 1'b1;
    else if (!eraseIn)      seqFired <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            secureOn <= 1'b0;
    else if (strb.clrSec) secureOn <= 1'b0;
    else if (strb.setSec) secureOn <= 1'b1;
  end

endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              lockHit,
  input  logic              qualified,
  input  logic              seqFired,
  input  logic              lowPowerDeep,
  input  logic              flashEraseAllDone,
  output fg_strobe_t        strb,
  output logic              cmdDone,
  output logic              cmdErr,
  output logic              irq,
  output logic              flashPgmStb,
  output logic              flashErsStb,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashEraseAllStb
);

  typedef enum logic {ST_IDLE, ST_WIPE} state_e;
  state_e state;

  logic busy, startSeq, accept, isAccess, known;

  always_comb begin
    busy     = (state == ST_WIPE);
    startSeq = !busy && qualified && !seqFired && !lowPowerDeep;
    accept   = cmdValid && !busy && !startSeq;
    isAccess = (cmdOp == OP_PROGRAM) || (cmdOp == OP_ERASE);
    known    = isAccess || (cmdOp == OP_SETLOCK) || (cmdOp == OP_CLRLOCK) ||
               (cmdOp == OP_SETSEC);
    strb           = '0;
    strb.setLock   = accept && (cmdOp == OP_SETLOCK);
    strb.clrLock   = accept && (cmdOp == OP_CLRLOCK);
    strb.setSec    = accept && (cmdOp == OP_SETSEC);
    strb.wipeLocks = startSeq;
    strb.startSeq  = startSeq;
    strb.clrSec    = busy && flashEraseAllDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state            <= ST_IDLE;
      cmdDone          <= 1'b0;
      cmdErr           <= 1'b0;
      irq              <= 1'b0;
      flashPgmStb      <= 1'b0;
      flashErsStb      <= 1'b0;
      flashAddr        <= '0;
      flashEraseAllStb <= 1'b0;
    end else begin
      cmdDone          <= cmdValid;
      cmdErr           <= cmdValid && (!accept || !known || (isAccess && lockHit));
      irq              <= accept && isAccess && lockHit;
      flashPgmStb      <= accept && (cmdOp == OP_PROGRAM) && !lockHit;
      flashErsStb      <= accept && (cmdOp == OP_ERASE) && !lockHit;
      flashEraseAllStb <= startSeq;
      if (accept && isAccess) flashAddr <= cmdAddr;
      if (startSeq)                       state <= ST_WIPE;
      else if (busy && flashEraseAllDone) state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int NUM_REGIONS  = 128,
  parameter int REGION_BYTES = 8192,
  parameter int QUAL_CYCLES  = 64,
  localparam int ADDR_W      = $clog2(NUM_REGIONS) + $clog2(REGION_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdDone,
  output logic              cmdErr,
  output logic              irq,
  output logic              flashPgmStb,
  output logic              flashErsStb,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashEraseAllStb,
  input  logic              flashEraseAllDone,
  input  logic              eraseIn,
  input  logic              lowPowerDeep,
  output logic              secureOn,
  output logic              dbgEnable,
  output logic              fastPgmEnable
);

  fg_strobe_t strb;
  logic lockHit, qualified, seqFired;

  fg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .lockHit(lockHit), .qualified(qualified), .seqFired(seqFired),
    .lowPowerDeep(lowPowerDeep), .flashEraseAllDone(flashEraseAllDone),
    .strb(strb), .cmdDone(cmdDone), .cmdErr(cmdErr), .irq(irq),
    .flashPgmStb(flashPgmStb), .flashErsStb(flashErsStb), .flashAddr(flashAddr),
    .flashEraseAllStb(flashEraseAllStb)
  );

  fg_datapath #(
    .NUM_REGIONS(NUM_REGIONS), .REGION_BYTES(REGION_BYTES),
    .QUAL_CYCLES(QUAL_CYCLES), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr), .eraseIn(eraseIn),
    .lockHit(lockHit), .qualified(qualified), .seqFired(seqFired), .secureOn(secureOn)
  );

  assign dbgEnable     = !secureOn;
  assign fastPgmEnable = !secureOn;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdDone,
  input logic cmdErr,
  input logic irq,
  input logic flashPgmStb,
  input logic flashErsStb,
  input logic flashEraseAllStb,
  input logic flashEraseAllDone,
  input logic eraseIn,
  input logic lowPowerDeep,
  input logic secureOn
);

  // R2: an aborted request never reaches the back end
  a_r2_no_strobe_on_err: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> !flashPgmStb && !flashErsStb);

  // R2: the interrupt only accompanies a completed, failed request
  a_r2_irq_with_err: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> cmdDone && cmdErr);

  // R3: a page strobe only appears as a successful completion
  a_r3_strobe_done: assert property (@(posedge clk) disable iff (!rstN)
    (flashPgmStb || flashErsStb) |-> cmdDone && !cmdErr);

  // R3: completion follows a request by one cycle
  a_r3_done_after_req: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> cmdDone);

  // R7: the whole-array request is a single-cycle pulse
  a_r7_erase_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flashEraseAllStb |=> !flashEraseAllStb);

  // R9: no sequence starts out of deep low power
  a_r9_lowpower_gate: assert property (@(posedge clk) disable iff (!rstN)
    flashEraseAllStb |-> !$past(lowPowerDeep) && $past(eraseIn));

  // R8: security only falls after the back end reports completion
  a_r8_sec_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(secureOn) |-> $past(flashEraseAllDone));

endmodule

bind flash_guard flash_guard_chk u_chk (.*);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;

  localparam int NR = 8;
  localparam int RB = 256;
  localparam int QC = 8;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic flashEraseAllDone = 1'b0;
  logic eraseIn = 1'b0;
  logic lowPowerDeep = 1'b0;
  logic cmdDone, cmdErr, irq, flashPgmStb, flashErsStb, flashEraseAllStb;
  logic [AW-1:0] flashAddr;
  logic secureOn, dbgEnable, fastPgmEnable;

  int nChecks = 0;
  int nErr = 0;
  int wipeCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_guard #(.NUM_REGIONS(NR), .REGION_BYTES(RB), .QUAL_CYCLES(QC)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdDone(cmdDone), .cmdErr(cmdErr), .irq(irq), .flashPgmStb(flashPgmStb),
    .flashErsStb(flashErsStb), .flashAddr(flashAddr), .flashEraseAllStb(flashEraseAllStb),
    .flashEraseAllDone(flashEraseAllDone), .eraseIn(eraseIn), .lowPowerDeep(lowPowerDeep),
    .secureOn(secureOn), .dbgEnable(dbgEnable), .fastPgmEnable(fastPgmEnable)
  );

  always @(negedge clk) if (flashEraseAllStb) wipeCount++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; drives one request and samples its completion one edge later
  task automatic cmd(input logic [2:0] op, input int addr, input bit expErr, input bit expIrq,
                     input bit expPgm, input bit expErs, input string req);
    logic [4:0] act, exp;
    cmdValid = 1'b1; cmdOp = op; cmdAddr = AW'(addr);
    @(negedge clk);
    cmdValid = 1'b0;
    act = {cmdDone, cmdErr, irq, flashPgmStb, flashErsStb};
    exp = {1'b1, expErr, expIrq, expPgm, expErs};
    check(act == exp && (!(expPgm || expErs) || flashAddr == AW'(addr)), req,
          {act, 16'(flashAddr)}, {exp, 16'(addr)});
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check({cmdDone, cmdErr, irq, flashPgmStb, flashErsStb, flashEraseAllStb, secureOn} == 0 &&
          dbgEnable && fastPgmEnable, "R12 reset outputs",
          {cmdDone, cmdErr, irq, flashPgmStb, flashErsStb, flashEraseAllStb, secureOn, dbgEnable, fastPgmEnable},
          32'h3);
    for (int r = 0; r < NR; r++) cmd(3'd4, r*RB + 17, 0, 0, 1, 0, "R12 regions unprotected after reset");

    // R1 R2 R3 R4 protection sweep
    foreach (pats[p]) begin
      for (int r = 0; r < NR; r++)
        cmd(pats[p][r] ? 3'd1 : 3'd2, r*RB + 3*r, 0, 0, 0, 0, "R4 protect or unprotect completes");
      for (int r = 0; r < NR; r++) begin
        cmd(3'd4, r*RB, pats[p][r], pats[p][r], !pats[p][r], 0, "R1 R2 R3 program low address");
        cmd(3'd5, r*RB + RB - 1, pats[p][r], pats[p][r], 0, !pats[p][r], "R1 R2 R3 erase high address");
      end
    end

    // R10 unknown codes, protection state left as all-protected
    cmd(3'd0, 5, 1, 0, 0, 0, "R10 code 0 rejected");
    cmd(3'd6, 5, 1, 0, 0, 0, "R10 code 6 rejected");
    cmd(3'd7, 5, 1, 0, 0, 0, "R10 code 7 rejected");
    cmd(3'd4, 5, 1, 1, 0, 0, "R10 unknown code left protection intact");

    // R5 security on, then every code tried
    cmd(3'd3, 0, 0, 0, 0, 0, "R5 enable security");
    check(secureOn && !dbgEnable && !fastPgmEnable, "R5 gates closed",
          {secureOn, dbgEnable, fastPgmEnable}, 3'b100);
    for (int op = 0; op < 8; op++) begin
      cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = AW'(op*RB);
      @(negedge clk);
      cmdValid = 1'b0;
      check(secureOn, "R5 no command clears security", secureOn, 1);
    end
    for (int r = 0; r < NR; r++) cmd(3'd1, r*RB, 0, 0, 0, 0, "R4 reprotect all");

    // R6 short pulses, including a split one
    eraseIn = 1'b1; repeat (QC - 1) @(negedge clk);
    eraseIn = 1'b0; @(negedge clk);
    eraseIn = 1'b1; repeat (QC - 1) @(negedge clk);
    eraseIn = 1'b0; repeat (3) @(negedge clk);
    check(wipeCount == 0, "R6 short pulses ignored", wipeCount, 0);
    cmd(3'd4, 2*RB, 1, 1, 0, 0, "R6 protection kept after short pulses");

    // R9 qualified under low power
    lowPowerDeep = 1'b1;
    eraseIn = 1'b1; repeat (QC + 6) @(negedge clk);
    check(wipeCount == 0, "R9 held off in low power", wipeCount, 0);
    lowPowerDeep = 1'b0;
    @(negedge clk);
    check(flashEraseAllStb == 1'b1, "R9 R7 starts after low power ends", flashEraseAllStb, 1);
    @(negedge clk);
    check(flashEraseAllStb == 1'b0, "R7 single-cycle pulse", flashEraseAllStb, 0);

    // R8 R10 pending erase
    repeat (4) @(negedge clk);
    check(secureOn, "R8 security held while pending", secureOn, 1);
    cmd(3'd4, RB, 1, 0, 0, 0, "R10 request during sequence rejected");
    check(secureOn, "R8 security held after busy request", secureOn, 1);
    flashEraseAllDone = 1'b1; @(negedge clk);
    flashEraseAllDone = 1'b0;
    check(!secureOn && dbgEnable && fastPgmEnable, "R8 security released",
          {secureOn, dbgEnable, fastPgmEnable}, 3'b011);

    // R11 line still high
    repeat (3 * QC) @(negedge clk);
    check(wipeCount == 1, "R11 single sequence per high period", wipeCount, 1);
    eraseIn = 1'b0; @(negedge clk);

    // R7 all regions unprotected
    for (int r = 0; r < NR; r++) cmd(3'd5, r*RB + 100, 0, 0, 0, 1, "R7 protection cleared");

    // R6 exact qualification count
    eraseIn = 1'b1;
    for (int i = 0; i < QC; i++) begin
      @(negedge clk);
      check(!flashEraseAllStb, "R6 not before qualification", flashEraseAllStb, 0);
    end
    @(negedge clk);
    check(flashEraseAllStb, "R6 qualified after full count", flashEraseAllStb, 1);
    eraseIn = 1'b0;
    flashEraseAllDone = 1'b1; @(negedge clk);
    flashEraseAllDone = 1'b0; @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule